// File: doc/BRIEF.md
# DPLL Lock Calibration Sequencer

This block steers a digital PLL into lock during bring-up. On a start pulse it computes a pair of frequency limits from an initial low limit and a clock-band index. It drives them to the PLL as one control word with a tuning-enable flag set. It then watches the PLL's lock indicator. The indicator is polled once every `POLL_GAP` clocks, for at most `POLL_LIMIT` polls. After the first poll that shows lock, the sequencer requires lock to stay high on `HOLD_LIMIT` consecutive clocks.

An attempt fails when lock never shows up or when it drops during confirmation. The sequencer then widens the limits by a growing step, alternating between the low and the high side, and tries again. It makes at most `MAX_TRIES` attempts. When an attempt passes, the tuning flag is dropped and a success flag is raised. When every attempt fails, a failure flag is raised and the tuning flag stays set. Either flag stays set until the next start is accepted.

The control word has a fixed layout, because the PLL decodes it. The high limit sits in bits 31:16. The tuning-enable flag is bit 8. The low limit sits in bits 7:0. All other bits read zero.

States:
- `ST_IDLE`: after reset.
- `ST_SETTLE`: interval wait and poll.
- `ST_CONFIRM`: consecutive lock samples.
- `ST_RETUNE`: limit nudge, or the decision to give up.
- `ST_LOCKED`: success, sticky.
- `ST_GAVE_UP`: failure, sticky.

Transitions:
- IDLE/LOCKED/GAVE_UP → SETTLE on start.
- SETTLE → CONFIRM when a poll sees lock.
- SETTLE → RETUNE when the last poll misses.
- CONFIRM → RETUNE on any lost sample.
- CONFIRM → LOCKED on the last good sample.
- RETUNE → SETTLE while attempts remain.
- RETUNE → GAVE_UP after the final attempt.

Top module: `dpll_cal_seq`

## Requirements
- R1: While reset is applied and right after it, `busy`, `cal_ok` and `cal_fail` are 0 and `limit_word` is all zeros.
- R2: A start seen at a clock edge while idle, locked or given up loads the limits. Low = `init_low`. High = `init_low` + 2, plus a further 2 when `band_idx` is greater than 1. From the next cycle, `limit_word` = {high[15:0], 7'b0, 1'b1, low[7:0]}, `busy` is 1 and both result flags are 0.
- R3: The lock input is sampled `POLL_GAP` clock edges after an attempt begins, and again every `POLL_GAP` edges, at most `POLL_LIMIT` times. If the last of these samples shows no lock, the attempt fails. An attempt that times out lasts `POLL_LIMIT*POLL_GAP + 1` edges, including the retune edge.
- R4: After a poll sees lock, lock is sampled on each of the next `HOLD_LIMIT` edges. The first low sample fails the attempt at that edge, without waiting for the rest of the window.
- R5: If all confirmation samples are high, `cal_ok` is set on the edge of the last sample. `busy` falls on that same edge. Bit 8 of `limit_word` clears and both limits are kept.
- R6: After failed attempt k (counting from 0) with k < `MAX_TRIES`-1, the limits change and the next attempt begins one edge after the failing sample. If k is odd, low is reduced by k>>1. If k is even, high is raised by k>>1. Bit 8 stays set.
- R7: When attempt `MAX_TRIES`-1 fails, `cal_fail` is set one edge after the failing sample. `busy` falls and bit 8 stays set. The limits are those left after the earlier nudges.
- R8: `cal_ok` and `cal_fail` hold until a start is accepted. A start while `busy` is ignored: it affects neither the timing nor the limits of the run in progress.
- R9: At most one of `busy`, `cal_ok` and `cal_fail` is high at a time. `busy` only falls when one of the result flags rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| lock_in | input | 1 | Lock indicator from the PLL |
| init_low | input | 8 | Initial low frequency limit |
| band_idx | input | 2 | Measured clock-band index (0..3) |
| limit_word | output | 32 | PLL control word: high limit 31:16, tuning enable bit 8, low limit 7:0 |
| busy | output | 1 | Calibration in progress |
| cal_ok | output | 1 | Sticky: lock achieved and confirmed |
| cal_fail | output | 1 | Sticky: every attempt failed |

## Verification
Most internal faults shift the edge at which a result flag rises. Examples are an interval counter off by one, a poll or hold count that ends one short, a confirm failure that waits out the window, or an attempt counter that skips. So each run checks that the flag is still low one cycle before the predicted edge and high on it; any such error shows up within the same run. A wrong nudge direction, a wrong step or a wrong initial high limit stays visible in `limit_word` for the rest of the run. The sweep over band index and over the number of failed attempts (0 through all of them) reaches every nudge step.

// File: rtl/dpll_cal_pkg.sv
package dpll_cal_pkg;

    // Control word layout, fixed because the PLL decodes it.
    localparam int LOW_W    = 8;
    localparam int TUNE_BIT = 8;
    localparam int HIGH_LSB = 16;
    localparam int HIGH_W   = 16;
    localparam int WORD_W   = HIGH_LSB + HIGH_W;
    localparam int GAP_W    = HIGH_LSB - TUNE_BIT - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CONFIRM,
        ST_RETUNE,
        ST_LOCKED,
        ST_GAVE_UP
    } cal_state_e;

    // High limit starts 2 above the low limit, 4 above for the faster bands.
    function automatic logic [HIGH_W-1:0] first_high(input logic [LOW_W-1:0] lo,
                                                     input logic [1:0] band);
        logic [HIGH_W-1:0] extra;
        extra = (band > 2'd1) ? HIGH_W'(4) : HIGH_W'(2);
        return HIGH_W'(lo) + extra;
    endfunction

endpackage

// File: rtl/dpll_cal_count.sv
module dpll_cal_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dpll_cal_limits.sv
module dpll_cal_limits
    import dpll_cal_pkg::*;
#(
    parameter int KW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              nudge,
    input  logic              lock_ok,
    input  logic [KW-1:0]     k_idx,
    input  logic [LOW_W-1:0]  init_low,
    input  logic [1:0]        band_idx,
    output logic [LOW_W-1:0]  low_q,
    output logic [HIGH_W-1:0] high_q,
    output logic              tune_q
);
    logic [KW-1:0] step;

    assign step = k_idx >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            tune_q <= 1'b0;
        end else if (load) begin
            low_q  <= init_low;
            high_q <= first_high(init_low, band_idx);
            tune_q <= 1'b1;
        end else if (nudge) begin
            // Odd attempts widen downward, even attempts widen upward.
            if (k_idx[0]) begin
                low_q <= low_q - LOW_W'(step);
            end else begin
                high_q <= high_q + HIGH_W'(step);
            end
        end else if (lock_ok) begin
            tune_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dpll_cal_fsm.sv
module dpll_cal_fsm
    import dpll_cal_pkg::*;
#(
    parameter int MAX_TRIES = 8,
    parameter int KW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          lock_in,
    input  logic          tick,
    input  logic          poll_last,
    input  logic          hold_last,
    output logic [KW-1:0] attempt,
    output logic          load,
    output logic          nudge,
    output logic          lock_ok,
    output logic          iv_clr,
    output logic          iv_inc,
    output logic          poll_clr,
    output logic          poll_inc,
    output logic          hold_clr,
    output logic          hold_inc,
    output logic          busy,
    output logic          ok,
    output logic          fail
);
    cal_state_e state, state_nx;
    logic       last_try;
    logic       resting;

    assign last_try = (attempt == KW'(MAX_TRIES - 1));
    assign resting  = (state == ST_IDLE) || (state == ST_LOCKED) || (state == ST_GAVE_UP);

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_LOCKED, ST_GAVE_UP: begin
                if (start) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tick) begin
                    if (lock_in)        state_nx = ST_CONFIRM;
                    else if (poll_last) state_nx = ST_RETUNE;
                end
            end
            ST_CONFIRM: begin
                if (!lock_in)       state_nx = ST_RETUNE;
                else if (hold_last) state_nx = ST_LOCKED;
            end
            ST_RETUNE: begin
                state_nx = last_try ? ST_GAVE_UP : ST_SETTLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and attempt index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            attempt <= '0;
        end else begin
            state <= state_nx;
            if (load) begin
                attempt <= '0;
            end else if (nudge) begin
                attempt <= attempt + 1'b1;
            end
        end
    end

    // Outputs and strobes.
    always_comb begin
        load     = resting && start;
        nudge    = (state == ST_RETUNE) && !last_try;
        lock_ok  = (state == ST_CONFIRM) && lock_in && hold_last;
        iv_inc   = (state == ST_SETTLE);
        iv_clr   = (state != ST_SETTLE) || tick;
        poll_clr = load || (state == ST_RETUNE);
        poll_inc = (state == ST_SETTLE) && tick && !lock_in;
        hold_inc = (state == ST_CONFIRM);
        hold_clr = (state != ST_CONFIRM);
        busy     = !resting;
        ok       = (state == ST_LOCKED);
        fail     = (state == ST_GAVE_UP);
    end
endmodule

// File: rtl/dpll_cal_seq.sv
module dpll_cal_seq
    import dpll_cal_pkg::*;
#(
    parameter int POLL_GAP   = 16,
    parameter int POLL_LIMIT = 20480,
    parameter int HOLD_LIMIT = 4096,
    parameter int MAX_TRIES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lock_in,
    input  logic [LOW_W-1:0]  init_low,
    input  logic [1:0]        band_idx,
    output logic [WORD_W-1:0] limit_word,
    output logic              busy,
    output logic              cal_ok,
    output logic              cal_fail
);
    localparam int KW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    logic          tick, poll_last, hold_last;
    logic          load, nudge, lock_ok;
    logic          iv_clr, iv_inc, poll_clr, poll_inc, hold_clr, hold_inc;
    logic [KW-1:0] attempt;
    logic [LOW_W-1:0]  low_q;
    logic [HIGH_W-1:0] high_q;
    logic              tune_q;

    dpll_cal_fsm #(.MAX_TRIES(MAX_TRIES), .KW(KW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .lock_in(lock_in),
        .tick(tick), .poll_last(poll_last), .hold_last(hold_last),
        .attempt(attempt), .load(load), .nudge(nudge), .lock_ok(lock_ok),
        .iv_clr(iv_clr), .iv_inc(iv_inc), .poll_clr(poll_clr), .poll_inc(poll_inc),
        .hold_clr(hold_clr), .hold_inc(hold_inc),
        .busy(busy), .ok(cal_ok), .fail(cal_fail)
    );

    dpll_cal_count #(.LIMIT(POLL_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(iv_clr), .inc(iv_inc), .at_last(tick)
    );

    dpll_cal_count #(.LIMIT(POLL_LIMIT)) u_polls (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .at_last(poll_last)
    );

    dpll_cal_count #(.LIMIT(HOLD_LIMIT)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(hold_clr), .inc(hold_inc), .at_last(hold_last)
    );

    dpll_cal_limits #(.KW(KW)) u_lim (
        .clk(clk), .rst_n(rst_n), .load(load), .nudge(nudge), .lock_ok(lock_ok),
        .k_idx(attempt), .init_low(init_low), .band_idx(band_idx),
        .low_q(low_q), .high_q(high_q), .tune_q(tune_q)
    );

    assign limit_word = {high_q, {GAP_W{1'b0}}, tune_q, low_q};
endmodule

// File: rtl/dpll_cal_checker.sv
module dpll_cal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        cal_ok,
    input logic        cal_fail,
    input logic [31:0] limit_word
);
    a_r9_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, cal_ok, cal_fail}));

    a_r9_busy_ends_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cal_ok || cal_fail));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && limit_word[8]));

    a_r8_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_ok && !start) |=> cal_ok);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_fail && !start) |=> cal_fail);

    a_r5_tune_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ok) |-> !limit_word[8]);

    a_r7_tune_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_fail) |-> limit_word[8]);

    a_r6_high_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (limit_word[31:16] >= $past(limit_word[31:16])));
endmodule

bind dpll_cal_seq dpll_cal_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cal_ok(cal_ok), .cal_fail(cal_fail), .limit_word(limit_word)
);

// File: tb/tb_dpll_cal_seq.sv
module tb_dpll_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GAP  = 3;
    localparam int PL   = 6;
    localparam int HOLD = 5;
    localparam int MT   = 8;
    localparam int ATT  = PL * GAP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lock_in = 1'b0;
    logic [7:0]  init_low = '0;
    logic [1:0]  band_idx = '0;
    logic [31:0] limit_word;
    logic        busy, cal_ok, cal_fail;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpll_cal_seq #(.POLL_GAP(GAP), .POLL_LIMIT(PL), .HOLD_LIMIT(HOLD), .MAX_TRIES(MT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lock_in(lock_in),
        .init_low(init_low), .band_idx(band_idx), .limit_word(limit_word),
        .busy(busy), .cal_ok(cal_ok), .cal_fail(cal_fail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Control word predicted from the requirements after nfail failed attempts.
    function automatic logic [31:0] exp_word(input int init, input int band,
                                             input int nfail, input bit tune);
        int hi;
        int lo;
        hi = init + 2 + ((band > 1) ? 2 : 0);
        lo = init;
        for (int k = 0; k < nfail && k < MT - 1; k++) begin
            if (k % 2 == 1) lo -= k >> 1;
            else            hi += k >> 1;
        end
        return {16'(hi), 7'd0, tune, 8'(lo)};
    endfunction

    task automatic kick(input int init, input int band);
        lock_in  = 1'b0;
        init_low = 8'(init);
        band_idx = 2'(band);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Lock stays away for nfail attempts, then arrives and holds.
    task automatic run_case(input int init, input int band, input int nfail);
        kick(init, band);
        check("R2 word after start", limit_word, exp_word(init, band, 0, 1'b1));
        check("R8 flags after start", {29'd0, busy, cal_ok, cal_fail}, 32'b100);
        if (nfail < MT) begin
            repeat (nfail * ATT) @(negedge clk);
            lock_in = 1'b1;
            repeat (GAP + HOLD - 1) @(negedge clk);
            check("R4 ok not before window end", {31'd0, cal_ok}, 32'd0);
            @(negedge clk);
            check("R5 ok on last sample", {29'd0, busy, cal_ok, cal_fail}, 32'b010);
            check("R6 limits after retries", limit_word, exp_word(init, band, nfail, 1'b0));
            lock_in = 1'b0;
            repeat (3) @(negedge clk);
            check("R8 ok sticky", {31'd0, cal_ok}, 32'd1);
        end else begin
            repeat (MT * ATT - 1) @(negedge clk);
            check("R3 still busy before give-up", {29'd0, busy, cal_ok, cal_fail}, 32'b100);
            @(negedge clk);
            check("R7 gave up", {29'd0, busy, cal_ok, cal_fail}, 32'b001);
            check("R7 word at give-up", limit_word, exp_word(init, band, MT, 1'b1));
            repeat (3) @(negedge clk);
            check("R8 fail sticky", {31'd0, cal_fail}, 32'd1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset flags", {29'd0, busy, cal_ok, cal_fail}, 32'd0);
        check("R1 reset word", limit_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {29'd0, busy, cal_ok, cal_fail}, 32'd0);

        // Sweep over band index and number of failed attempts.
        for (int band = 0; band < 4; band++) begin
            for (int nf = 0; nf <= MT; nf++) begin
                run_case(20 + band * 50 + nf, band, nf);
            end
        end

        // R3 boundary: lock first seen on the very last poll.
        kick(77, 1);
        repeat ((PL - 1) * GAP) @(negedge clk);
        lock_in = 1'b1;
        repeat (GAP + HOLD - 1) @(negedge clk);
        check("R3 last poll, not yet ok", {31'd0, cal_ok}, 32'd0);
        @(negedge clk);
        check("R3 lock on last poll accepted", {29'd0, busy, cal_ok, cal_fail}, 32'b010);
        check("R3 word first attempt", limit_word, exp_word(77, 1, 0, 1'b0));

        // R4: lock drops in the third confirmation sample, attempt fails at once.
        kick(90, 3);
        repeat (GAP) @(negedge clk);
        lock_in = 1'b1;
        repeat (GAP + 2) @(negedge clk);
        lock_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 retune started", {29'd0, busy, cal_ok, cal_fail}, 32'b100);
        lock_in = 1'b1;
        repeat (GAP + HOLD - 1) @(negedge clk);
        check("R4 early fail timing, not yet ok", {31'd0, cal_ok}, 32'd0);
        @(negedge clk);
        check("R4 early fail timing, ok", {31'd0, cal_ok}, 32'd1);
        check("R6 word after one failure", limit_word, exp_word(90, 3, 1, 1'b0));

        // R8: start while busy is ignored.
        kick(33, 0);
        lock_in = 1'b1;
        repeat (2) @(negedge clk);
        init_low = 8'd200;
        band_idx = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (GAP + HOLD - 4) @(negedge clk);
        check("R8 busy start no delay, not yet", {31'd0, cal_ok}, 32'd0);
        @(negedge clk);
        check("R8 busy start ignored timing", {31'd0, cal_ok}, 32'd1);
        check("R8 busy start ignored word", limit_word, exp_word(33, 0, 0, 1'b0));
        lock_in = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule